// File: doc/BRIEF.md
# Four-Sample Early/Late Phase Detector

This block makes the binary timing decision for clock recovery on full-rate non-return-to-zero data. Every recovered-clock cycle it receives two samples of the serial stream: one taken in the middle of the current bit and one taken on the boundary between the previous bit and the current one. A short flop chain lines these up, so that the previous centre sample, the boundary sample and the current centre sample can be compared as one triple.

If a transition took place and the boundary sample agrees with the new bit, the clock is late. The block then emits a one-cycle UP pulse so that the loop raises the oscillator control. If the boundary sample still holds the old bit, the clock is early and a one-cycle DN pulse lowers it. When no transition occurred there is no timing information, and the block emits nothing. During a run of equal bits the outputs therefore stay low instead of holding the last decision, and the control moves only once per data transition. The loop filter and the oscillator lie outside this block.

Top module: `bangbang_pd`

## Requirements
- R1: While `rst` is high, and after it falls until two centre samples have been captured, `up_o` and `dn_o` are 0. The first possible pulse appears after the third rising edge following reset release.
- R2: Let A be the previous centre sample, T the boundary sample taken between A and the current centre sample, and B the current centre sample. When A differs from T and T equals B (clock late), `up_o` is 1 for exactly the cycle that follows the edge on which B was captured.
- R3: When A equals T and T differs from B (clock early), `dn_o` is 1 in that same cycle.
- R4: When A equals B, both outputs are 0 in that cycle, whatever the value of T.
- R5: `up_o` and `dn_o` are never 1 in the same cycle.
- R6: A correction lasts one cycle. In a run of identical bits that follows a transition, the pulse caused by the transition is not repeated, and the outputs return to 0 on the next cycle.
- R7: The outputs are registered. Each decision appears one clock after the rising edge that captured B, which is two edges after `mid_smp_i`/`bnd_smp_i` for B are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered clock; all flops use its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mid_smp_i | input | 1 | Data sample taken at the centre of the current bit |
| bnd_smp_i | input | 1 | Data sample taken on the boundary just before the current bit |
| up_o | output | 1 | One-cycle request to raise the control (clock late) |
| dn_o | output | 1 | One-cycle request to lower the control (clock early) |

## Verification
Two things can land on the same output edge. One is the end of the start-up fill window, during which the outputs are blocked. The other is a data transition whose boundary sample, taken alone, would call for a pulse. The bench places a transition in the first bits after reset and checks that the earliest pulse appears no sooner than R1 allows. Random boundary values then make UP and DN candidates follow each other cycle after cycle, and the bench checks every cycle that at most one output is high and that it matches the triple computed from the stimulus history.

// File: rtl/bangbang_pd_pkg.sv
package bangbang_pd_pkg;

    // Number of centre samples that must be captured before a decision is valid
    localparam int unsigned PRIME_SAMPLES = 2;
    localparam int unsigned PRIME_W       = $clog2(PRIME_SAMPLES + 1);

    // Aligned sample triple: earlier centre, boundary between them, later centre
    typedef struct packed {
        logic prev_mid;
        logic bnd;
        logic cur_mid;
    } smp_trio_t;

    typedef enum logic [1:0] {
        VERD_HOLD = 2'b00,
        VERD_UP   = 2'b01,
        VERD_DN   = 2'b10
    } verdict_t;

    // Late clock: boundary already shows the new bit. Early: it still shows the old one.
    function automatic verdict_t classify(input smp_trio_t t);
        verdict_t v;
        v = VERD_HOLD;
        if (t.prev_mid != t.cur_mid) begin
            if (t.bnd == t.cur_mid) v = VERD_UP;
            else                    v = VERD_DN;
        end
        return v;
    endfunction

endpackage

// File: rtl/bangbang_pd_sampler.sv
module bangbang_pd_sampler
    import bangbang_pd_pkg::*;
#(
    parameter int unsigned PRIME = PRIME_SAMPLES
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      mid_smp_i,
    input  logic      bnd_smp_i,
    output smp_trio_t trio_o,
    output logic      valid_o
);
    localparam int unsigned CW = $clog2(PRIME + 1);

    logic          mid_cur_q;
    logic          mid_prev_q;
    logic          bnd_q;
    logic [CW-1:0] fill_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mid_cur_q  <= 1'b0;
            mid_prev_q <= 1'b0;
            bnd_q      <= 1'b0;
            fill_q     <= '0;
        end else begin
            mid_cur_q  <= mid_smp_i;
            mid_prev_q <= mid_cur_q;
            bnd_q      <= bnd_smp_i;
            if (fill_q != CW'(PRIME)) fill_q <= fill_q + 1'b1;
        end
    end

    always_comb begin
        trio_o.prev_mid = mid_prev_q;
        trio_o.bnd      = bnd_q;
        trio_o.cur_mid  = mid_cur_q;
    end

    assign valid_o = (fill_q == CW'(PRIME));

    // R1: fill counter never exceeds its limit
    assert_fill_bound_R1: assert property (@(posedge clk) disable iff (rst)
        fill_q <= CW'(PRIME));
endmodule

// File: rtl/bangbang_pd_decide.sv
module bangbang_pd_decide
    import bangbang_pd_pkg::*;
(
    input  smp_trio_t trio_i,
    input  logic      valid_i,
    output verdict_t  verd_o
);
    always_comb begin
        verd_o = VERD_HOLD;
        if (valid_i) verd_o = classify(trio_i);
    end
endmodule

// File: rtl/bangbang_pd_pulse.sv
module bangbang_pd_pulse
    import bangbang_pd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  verdict_t verd_i,
    output logic     up_o,
    output logic     dn_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            up_o <= 1'b0;
            dn_o <= 1'b0;
        end else begin
            up_o <= (verd_i == VERD_UP);
            dn_o <= (verd_i == VERD_DN);
        end
    end

    // R5: outputs mutually exclusive
    assert_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(up_o && dn_o));
endmodule

// File: rtl/bangbang_pd.sv
module bangbang_pd
    import bangbang_pd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mid_smp_i,
    input  logic bnd_smp_i,
    output logic up_o,
    output logic dn_o
);
    smp_trio_t trio;
    logic      valid;
    verdict_t  verd;

    bangbang_pd_sampler #(.PRIME(PRIME_SAMPLES)) u_smp (
        .clk       (clk),
        .rst       (rst),
        .mid_smp_i (mid_smp_i),
        .bnd_smp_i (bnd_smp_i),
        .trio_o    (trio),
        .valid_o   (valid)
    );

    bangbang_pd_decide u_dec (
        .trio_i  (trio),
        .valid_i (valid),
        .verd_o  (verd)
    );

    bangbang_pd_pulse u_pls (
        .clk    (clk),
        .rst    (rst),
        .verd_i (verd),
        .up_o   (up_o),
        .dn_o   (dn_o)
    );

    // R1: no pulse while history is incomplete
    assert_quiet_fill_R1: assert property (@(posedge clk) disable iff (rst)
        !valid |=> (!up_o && !dn_o));
    // R2 / R7: late triple yields UP one clock later
    assert_late_up_R2: assert property (@(posedge clk) disable iff (rst)
        (valid && trio.prev_mid != trio.bnd && trio.bnd == trio.cur_mid) |=> up_o);
    // R3 / R7: early triple yields DN one clock later
    assert_early_dn_R3: assert property (@(posedge clk) disable iff (rst)
        (valid && trio.prev_mid == trio.bnd && trio.bnd != trio.cur_mid) |=> dn_o);
    // R4: no transition, no correction
    assert_run_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (trio.prev_mid == trio.cur_mid) |=> (!up_o && !dn_o));
endmodule

// File: tb/bangbang_pd_test.sv
module bangbang_pd_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NBITS      = 3000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mid_smp_i = 1'b0;
    logic bnd_smp_i = 1'b0;
    logic up_o, dn_o;

    int checks = 0;
    int errors = 0;
    logic mid_h [NBITS];
    logic bnd_h [NBITS];

    bangbang_pd uut (
        .clk(clk), .rst(rst), .mid_smp_i(mid_smp_i), .bnd_smp_i(bnd_smp_i),
        .up_o(up_o), .dn_o(dn_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic want_up(input logic a, input logic t, input logic b);
        return (a != t) && (t == b);
    endfunction
    function automatic logic want_dn(input logic a, input logic t, input logic b);
        return (a == t) && (t != b);
    endfunction

    task automatic check(input string tag, input logic eu, input logic ed);
        checks++;
        if (up_o !== eu || dn_o !== ed) begin
            errors++;
            $display("FAIL %s: up/dn actual %b%b expected %b%b at %0t", tag, up_o, dn_o, eu, ed, $time);
        end
        checks++;
        if (up_o === 1'b1 && dn_o === 1'b1) begin
            errors++;
            $display("FAIL R5: up/dn actual 11 expected not both at %0t", $time);
        end
    endtask

    initial begin
        int dummy;
        logic prev_pulse;
        dummy = $urandom(32'd20240611);
        // Directed prefix: transition right after reset, late run, early run, glitches
        for (int i = 0; i < NBITS; i++) begin
            if (i < 24) begin
                mid_h[i] = (i inside {[1:5], [12:13], [18:18]});
                if (i == 0)       bnd_h[i] = 1'b0;
                else if (i < 12)  bnd_h[i] = mid_h[i];       // late clock
                else if (i < 18)  bnd_h[i] = mid_h[i-1];     // early clock
                else              bnd_h[i] = ~mid_h[i-1];    // boundary glitch inside runs
            end else begin
                mid_h[i] = ($urandom_range(0, 2) == 0) ? ~mid_h[i-1] : mid_h[i-1];
                case ($urandom_range(0, 2))
                    0:       bnd_h[i] = mid_h[i];
                    1:       bnd_h[i] = mid_h[i-1];
                    default: bnd_h[i] = 1'($urandom_range(0, 1));
                endcase
            end
        end

        repeat (3) @(negedge clk);
        check("R1 reset", 1'b0, 1'b0);
        rst = 1'b0;
        prev_pulse = 1'b0;
        for (int i = 0; i < NBITS; i++) begin
            mid_smp_i = mid_h[i];
            bnd_smp_i = bnd_h[i];
            @(posedge clk);
            @(negedge clk);
            if (i < 2) begin
                check("R1 fill", 1'b0, 1'b0);
                prev_pulse = 1'b0;
            end else begin
                logic a, t, b, eu, ed;
                a = mid_h[i-2]; t = bnd_h[i-1]; b = mid_h[i-1];
                eu = want_up(a, t, b);
                ed = want_dn(a, t, b);
                if (eu)               check("R2 R7 late", eu, ed);
                else if (ed)          check("R3 R7 early", eu, ed);
                else if (prev_pulse)  check("R6 single pulse", eu, ed);
                else                  check("R4 run", eu, ed);
                prev_pulse = eu | ed;
            end
        end
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 reassert", 1'b0, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule